// File: doc/BRIEF.md
# TDM Frame-Pulse Audio Serializer

This block turns per-channel audio sample words into a single-phase, multi-channel serial stream. The whole block runs on the incoming bit clock: every rising edge advances the frame by one bit period. Each frame begins with a one-cycle frame pulse on `fsync`. The channel words follow back-to-back on `sdata`, MSB first, starting in the cycle after the pulse. Any cycles that remain before the next pulse carry zeros. A receiver samples `sdata` and `fsync` on the falling edge.

Software or an upstream stage places one sample per channel into a small set of holding registers through a valid/ready handshake. The serializer takes each word at the start of its slot. If a word that a slot needs is missing, the slot is sent as zeros and a sticky underrun flag is raised. The frame is set up by three configuration inputs: word length, channel mask and frame length in bit cycles. A configuration that cannot fit is reported on `cfg_err` and produces no frames.

Top module: `tdm_serializer`

## Requirements
- R1: `cfg_err` is high when `cfg_wlen` is outside 8..24, when `cfg_mask` is zero, or when `cfg_fbits` is less than `cfg_wlen` times the channel count. While it is high the block halts: from the next rising edge `fsync` and `sdata` stay low.
- R2: With a valid configuration, frames repeat every `cfg_fbits`+1 bit cycles. `fsync` is high in exactly the first cycle of each frame. The first pulse appears one cycle after the configuration becomes valid.
- R3: The channel count is one plus the index of the highest set bit of `cfg_mask`. Slots 0 up to count-1 follow the pulse cycle back-to-back, `cfg_wlen` cycles each. Each slot sends bits `cfg_wlen`-1 down to 0 of its stored 24-bit sample, MSB first, so the upper bits are ignored.
- R4: In the pulse cycle, `sdata` repeats the value of the cycle before it. When words fill the frame back-to-back (`cfg_fbits` equals the word length times the count), this is the LSB of the previous frame's last word. Otherwise it is 0.
- R5: The cycles after the last slot and before the next pulse drive `sdata` low.
- R6: A slot below the channel count whose mask bit is 0 sends zeros. It does not consume a stored sample and does not raise underrun.
- R7: `s_ready` is high when the holding register for `s_chan` is empty. A word is stored when `s_valid` and `s_ready` are both high. A write to a full register is refused and the stored word is unchanged. The register is emptied when its slot starts.
- R8: An enabled slot whose holding register is empty in the cycle before its first bit is sent as zeros and sets `urun`. `urun` stays set until `urun_clr` is high at a rising edge; a new underrun in that same cycle wins.
- R9: While reset is asserted, `fsync`, `sdata` and `urun` are low and all holding registers are empty (`s_ready` high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wlen | input | 5 | Word length in bits (8..24) |
| cfg_mask | input | 8 | Channel enable mask, bit i for slot i |
| cfg_fbits | input | 9 | Bit cycles per frame after the pulse cycle |
| s_valid | input | 1 | Sample write request |
| s_chan | input | 3 | Channel index of the sample write |
| s_data | input | 24 | Sample word |
| s_ready | output | 1 | Holding register of `s_chan` is empty |
| urun_clr | input | 1 | Write-one clear of `urun` |
| fsync | output | 1 | Frame pulse, one cycle per frame |
| sdata | output | 1 | Serial data |
| urun | output | 1 | Sticky underrun flag |
| cfg_err | output | 1 | Configuration invalid; block halted |

## Verification
The first frame pulse appears one rising edge after a valid configuration is applied. The MSB of slot 0 follows one edge later, and every later bit is due exactly one edge after the bit before it. The bench therefore queues the complete expected `fsync`/`sdata` stream of each frame, including pulse, data-delay, slot and idle cycles, before the edge that starts the frame. It compares one entry per cycle, 2 ns after each rising edge. `s_ready` responds to `s_chan` within the same cycle and becomes low after the accepting edge. `urun`, its clear and `cfg_err` are checked only after the stream has drained, or a fraction of a nanosecond after a negedge input change.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int SAMPLE_W = 24;
  localparam int MAX_CH   = 8;
  localparam int MIN_WLEN = 8;

  // number of slots spanned by a mask: index of the top set bit plus one
  function automatic int chan_span(input logic [31:0] mask);
    int n;
    n = 0;
    for (int i = 0; i < 32; i++) begin
      if (mask[i]) n = i + 1;
    end
    return n;
  endfunction
endpackage

// File: rtl/tdm_hold.sv
module tdm_hold #(
  parameter int NCH = 8,
  parameter int SW  = 24,
  localparam int CW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_ch,
  input  logic [SW-1:0] wr_data,
  output logic          wr_ready,
  input  logic          rd_en,
  input  logic [CW-1:0] rd_ch,
  output logic          rd_full,
  output logic [SW-1:0] rd_data
);
  logic [NCH-1:0] full_q, full_d;
  logic [SW-1:0]  mem_q [NCH];
  logic           acc;

  assign wr_ready = !full_q[wr_ch];
  assign acc      = wr_en && wr_ready;
  assign rd_full  = full_q[rd_ch];
  assign rd_data  = mem_q[rd_ch];

  always_comb begin
    full_d = full_q;
    if (rd_en) full_d[rd_ch] = 1'b0;
    if (acc)   full_d[wr_ch] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= '0;
    else        full_q <= full_d;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (acc && wr_ch == CW'(g)) mem_q[g] <= wr_data;
    end
  end

  AST_HOLD_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ready) |=> mem_q[$past(wr_ch)] == $past(mem_q[wr_ch])); // R7
endmodule

// File: rtl/tdm_framer.sv
module tdm_framer #(
  parameter int NCH = 8,
  parameter int SW  = 24,
  parameter int FBW = 9,
  localparam int CW  = $clog2(NCH),
  localparam int WLW = $clog2(SW + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [WLW-1:0] wlen,
  input  logic [CW:0]    nch,
  input  logic [FBW-1:0] fbits,
  output logic           fsync,
  output logic           dat,
  output logic           load,
  output logic [CW-1:0]  slot
);
  logic           run_q, run_d;
  logic [FBW-1:0] pos_q, pos_d;
  logic [CW-1:0]  slot_q, slot_d;
  logic [WLW-1:0] bit_q, bit_d;
  logic           dat_q, dat_d;
  logic           load_d;

  always_comb begin
    run_d  = run_q;
    pos_d  = pos_q;
    slot_d = slot_q;
    bit_d  = bit_q;
    dat_d  = dat_q;
    load_d = 1'b0;
    if (!go) begin
      run_d = 1'b0;
      pos_d = '0;
      dat_d = 1'b0;
    end else if (!run_q) begin
      run_d = 1'b1;
      pos_d = '0;
      dat_d = 1'b0;
    end else if (pos_q == fbits) begin
      pos_d = '0;
      dat_d = 1'b0;
    end else begin
      pos_d = pos_q + 1'b1;
      if (pos_q == '0) begin
        dat_d  = 1'b1;
        slot_d = '0;
        bit_d  = wlen - 1'b1;
        load_d = 1'b1;
      end else if (dat_q) begin
        if (bit_q == '0) begin
          if ((CW+1)'(slot_q) + 1'b1 < nch) begin
            slot_d = slot_q + 1'b1;
            bit_d  = wlen - 1'b1;
            load_d = 1'b1;
          end else begin
            dat_d = 1'b0;
          end
        end else begin
          bit_d = bit_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pos_q  <= '0;
      slot_q <= '0;
      bit_q  <= '0;
      dat_q  <= 1'b0;
    end else begin
      run_q  <= run_d;
      pos_q  <= pos_d;
      slot_q <= slot_d;
      bit_q  <= bit_d;
      dat_q  <= dat_d;
    end
  end

  assign fsync = run_q && (pos_q == '0);
  assign dat   = dat_q;
  assign load  = load_d;
  assign slot  = slot_d;

  AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> ((CW+1)'(slot) < nch)); // R3
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> !fsync); // R2
endmodule

// File: rtl/tdm_shifter.sv
module tdm_shifter #(
  parameter int SW = 24,
  localparam int WLW = $clog2(SW + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           shift,
  input  logic [SW-1:0]  word,
  input  logic [WLW-1:0] wlen,
  output logic           msb
);
  logic [SW-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load)       sh_d = word << (WLW'(SW) - wlen);
    else if (shift) sh_d = sh_q << 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign msb = sh_q[SW-1];
endmodule

// File: rtl/tdm_serializer.sv
module tdm_serializer #(
  parameter int NCH = tdm_pkg::MAX_CH,
  parameter int SW  = tdm_pkg::SAMPLE_W,
  parameter int FBW = 9,
  localparam int CW  = $clog2(NCH),
  localparam int WLW = $clog2(SW + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [WLW-1:0] cfg_wlen,
  input  logic [NCH-1:0] cfg_mask,
  input  logic [FBW-1:0] cfg_fbits,
  input  logic           s_valid,
  input  logic [CW-1:0]  s_chan,
  input  logic [SW-1:0]  s_data,
  output logic           s_ready,
  input  logic           urun_clr,
  output logic           fsync,
  output logic           sdata,
  output logic           urun,
  output logic           cfg_err
);
  logic [1:0]    rsync_q;
  logic          rst_i_n;
  int            span;
  logic [31:0]   need;
  logic [CW:0]   nch;
  logic          dat, load, msb;
  logic [CW-1:0] slot;
  logic          avail, take, urun_set;
  logic [SW-1:0] hdata;
  logic          last_q, urun_q, urun_d;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  always_comb begin
    span    = tdm_pkg::chan_span(32'(cfg_mask));
    need    = 32'(cfg_wlen) * 32'(span);
    cfg_err = (cfg_wlen < WLW'(tdm_pkg::MIN_WLEN)) || (cfg_wlen > WLW'(SW)) ||
              (span == 0) || (32'(cfg_fbits) < need);
  end
  assign nch = (CW+1)'(span);

  tdm_framer #(.NCH(NCH), .SW(SW), .FBW(FBW)) u_framer (
    .clk(clk), .rst_n(rst_i_n), .go(!cfg_err), .wlen(cfg_wlen), .nch(nch),
    .fbits(cfg_fbits), .fsync(fsync), .dat(dat), .load(load), .slot(slot)
  );

  tdm_hold #(.NCH(NCH), .SW(SW)) u_hold (
    .clk(clk), .rst_n(rst_i_n), .wr_en(s_valid), .wr_ch(s_chan), .wr_data(s_data),
    .wr_ready(s_ready), .rd_en(take), .rd_ch(slot), .rd_full(avail), .rd_data(hdata)
  );

  assign take     = load && cfg_mask[slot] && avail;
  assign urun_set = load && cfg_mask[slot] && !avail;

  tdm_shifter #(.SW(SW)) u_shift (
    .clk(clk), .rst_n(rst_i_n), .load(load), .shift(dat),
    .word(take ? hdata : '0), .wlen(cfg_wlen), .msb(msb)
  );

  // pulse cycle repeats the previous bit; idle cycles are zero
  assign sdata = dat ? msb : (fsync ? last_q : 1'b0);

  always_comb urun_d = (urun_q && !urun_clr) || urun_set;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      last_q <= 1'b0;
      urun_q <= 1'b0;
    end else begin
      last_q <= sdata;
      urun_q <= urun_d;
    end
  end
  assign urun = urun_q;

  AST_DELAY_REPEAT: assert property (@(posedge clk) disable iff (!rst_i_n)
    fsync |-> (sdata == $past(sdata))); // R4
  AST_HALT_ON_ERR: assert property (@(posedge clk) disable iff (!rst_i_n)
    cfg_err |=> (!fsync && !sdata)); // R1
  AST_URUN_STICKY: assert property (@(posedge clk) disable iff (!rst_i_n)
    (urun && !urun_clr) |=> urun); // R8
  AST_URUN_SET: assert property (@(posedge clk) disable iff (!rst_i_n)
    urun_set |=> urun); // R8
endmodule

// File: tb/sim_tdm_serializer.sv
module sim_tdm_serializer;
  localparam int NCH = 8;
  localparam int SW  = 24;
  localparam int FBW = 9;
  localparam int K_PULSE = 0, K_DATA = 1, K_DIS = 2, K_UR = 3, K_IDLE = 4;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [4:0]     cfg_wlen;
  logic [NCH-1:0] cfg_mask;
  logic [FBW-1:0] cfg_fbits;
  logic           s_valid;
  logic [2:0]     s_chan;
  logic [SW-1:0]  s_data;
  logic           s_ready, urun_clr, fsync, sdata, urun, cfg_err;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0]  expq[$];
  logic [7:0]  e;
  logic [23:0] bw[8];
  bit          bav[8];
  bit          prev;

  always #4 clk = ~clk;

  tdm_serializer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wlen(cfg_wlen), .cfg_mask(cfg_mask),
    .cfg_fbits(cfg_fbits), .s_valid(s_valid), .s_chan(s_chan), .s_data(s_data),
    .s_ready(s_ready), .urun_clr(urun_clr), .fsync(fsync), .sdata(sdata),
    .urun(urun), .cfg_err(cfg_err)
  );

  function automatic string kname(int k);
    case (k)
      K_PULSE: return "R2/R4 pulse cycle";
      K_DATA:  return "R3 slot data";
      K_DIS:   return "R6 disabled slot";
      K_UR:    return "R8 underrun slot";
      default: return "R5 idle cycle";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // monitor: one expected (fsync,sdata) pair per bit cycle
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expq.size() > 0) begin
        e = expq.pop_front();
        n_chk++;
        if (fsync !== e[1] || sdata !== e[0]) begin
          n_bad++;
          $display("FAIL %s: fsync,sdata got %b%b expected %b%b",
                   kname(int'(e[7:2])), fsync, sdata, e[1], e[0]);
        end
      end
    end
  end

  task automatic push(int k, bit fs, bit sd);
    expq.push_back({6'(k), fs, sd});
  endtask

  task automatic push_frames(int wl, logic [7:0] mask, int fb, int nfr);
    int nch = 0;
    bit b;
    for (int i = 0; i < 8; i++) if (mask[i]) nch = i + 1;
    for (int f = 0; f < nfr; f++) begin
      push(K_PULSE, 1'b1, prev);
      for (int s = 0; s < nch; s++) begin
        for (int j = wl - 1; j >= 0; j--) begin
          if (!mask[s])     begin b = 1'b0;     push(K_DIS, 1'b0, b);  end
          else if (bav[s])  begin b = bw[s][j]; push(K_DATA, 1'b0, b); end
          else              begin b = 1'b0;     push(K_UR, 1'b0, b);   end
          prev = b;
        end
      end
      for (int j = 0; j < fb - wl * nch; j++) begin
        push(K_IDLE, 1'b0, 1'b0);
        prev = 1'b0;
      end
      for (int s = 0; s < nch; s++) if (mask[s]) bav[s] = 1'b0;
    end
  endtask

  task automatic run_cfg(int wl, logic [7:0] mask, int fb, int nfr);
    @(negedge clk);
    cfg_wlen  = 5'(wl);
    cfg_fbits = FBW'(fb);
    cfg_mask  = mask;
    prev = 1'b0;
    push_frames(wl, mask, fb, nfr);
    while (expq.size() != 0) @(negedge clk);
    cfg_mask = '0;
    @(negedge clk);
  endtask

  task automatic wr(int ch, logic [23:0] d, bit exp_rdy);
    @(negedge clk);
    s_chan  = 3'(ch);
    s_data  = d;
    s_valid = 1'b1;
    #1 chk("R7 s_ready before write", 32'(s_ready), 32'(exp_rdy));
    @(negedge clk);
    s_valid = 1'b0;
    if (exp_rdy) begin
      bw[ch]  = d;
      bav[ch] = 1'b1;
    end
    #1 chk("R7 s_ready after write", 32'(s_ready), 32'd0);
  endtask

  task automatic clear_urun;
    @(negedge clk);
    urun_clr = 1'b1;
    @(negedge clk);
    urun_clr = 1'b0;
    #1 chk("R8 urun cleared", 32'(urun), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seen;
    rst_n = 1'b0; cfg_wlen = 5'd16; cfg_mask = '0; cfg_fbits = '0;
    s_valid = 1'b0; s_chan = '0; s_data = '0; urun_clr = 1'b0;
    for (int i = 0; i < 8; i++) begin bw[i] = '0; bav[i] = 1'b0; end
    repeat (3) @(negedge clk);
    chk("R9 fsync in reset", 32'(fsync), 0);
    chk("R9 sdata in reset", 32'(sdata), 0);
    chk("R9 urun in reset", 32'(urun), 0);
    chk("R9 s_ready in reset", 32'(s_ready), 1);
    chk("R1 zero mask flagged", 32'(cfg_err), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // two channels, idle tail, refused overwrite, then underrun frame
    wr(0, 24'h0000A5, 1'b1);
    wr(0, 24'h0000FF, 1'b0);
    wr(1, 24'hFFFF3C, 1'b1);
    run_cfg(8, 8'h03, 20, 2);
    chk("R8 urun after empty frame", 32'(urun), 1);
    clear_urun();

    // three slots, middle disabled, back-to-back frames
    wr(0, 24'h12C3A5, 1'b1);
    wr(1, 24'h005555, 1'b1);
    wr(2, 24'h00F00F, 1'b1);
    bav[1] = 1'b0;
    run_cfg(16, 8'h05, 48, 2);
    s_chan = 3'd1;
    #1 chk("R6 disabled slot kept its word", 32'(s_ready), 0);
    chk("R8 urun after back-to-back", 32'(urun), 1);
    clear_urun();

    // eight slots, only the top one enabled, full 24-bit words
    wr(7, 24'hABCDEF, 1'b1);
    run_cfg(24, 8'h80, 192, 1);
    chk("R6 disabled slots no underrun", 32'(urun), 0);

    // configuration errors
    @(negedge clk);
    cfg_wlen = 5'd16; cfg_mask = 8'h0F; cfg_fbits = 9'd63;
    #1 chk("R1 frame too short", 32'(cfg_err), 1);
    seen = 0;
    repeat (80) begin
      @(posedge clk); #2;
      if (fsync || sdata) seen++;
    end
    chk("R1 halted outputs stay low", 32'(seen), 0);
    @(negedge clk);
    cfg_fbits = 9'd64;
    #1 chk("R1 exact fit accepted", 32'(cfg_err), 0);
    cfg_mask = '0;
    cfg_wlen = 5'd7; cfg_fbits = 9'd100;
    #1 chk("R1 word length 7 refused", 32'(cfg_err), 1);
    cfg_mask = 8'h01;
    #1 chk("R1 word length 7 refused", 32'(cfg_err), 1);
    cfg_wlen = 5'd25;
    #1 chk("R1 word length 25 refused", 32'(cfg_err), 1);
    cfg_mask = '0;
    @(negedge clk);

    // minimum frame, back-to-back with LSB 1 repeated in the pulse
    wr(0, 24'h000081, 1'b1);
    run_cfg(8, 8'h01, 8, 2);
    chk("R8 urun after minimum frame", 32'(urun), 1);

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule